// File: doc/BRIEF.md
# Codec Clock Divider Chain

This block turns one fast master clock into the timing strobes that a voice-band codec needs. Every output is a one-cycle enable in the master clock domain. A prescaler divides the master clock by 1 to 5 and produces the device clock tick. A frame counter runs on that tick and produces two strobes: the serial bit tick, and the sample strobe that marks the point where the converter output frame begins. A comparator on the same counter produces the DAC load strobe. By default this strobe comes one serial bit period ahead of the sample strobe. It can be moved earlier in steps of one thirty-second of the frame.

The control fields can change at any time. The block copies them into an active set only on the cycle of a sample strobe. As a result, no period on any output is ever cut short or stretched in the middle of a frame. Reset loads an all-zero active set, which selects the slowest serial and sample rates.

Top module: `codec_clk_chain`

## Requirements
- R1: While rst_ni is low, sample_o, dac_load_o and sclk_en_o stay low. After reset the active controls are all zero: master ratio 1, serial ratio 8 and frame length 2048 device ticks.
- R2: Master divider codes 0, 1, 2, 3 and 4 on mdiv_sel_i give dmclk_en_o as a one-cycle pulse every 1, 2, 3, 4 or 5 master clock cycles.
- R3: Master divider codes 5, 6 and 7 behave as ratio 1, so dmclk_en_o is high on every cycle.
- R4: sclk_sel_i codes 0, 1, 2 and 3 give sclk_en_o on every 8th, 4th, 2nd or 1st device tick, and always on a device tick.
- R5: fs_sel_i codes 0, 1, 2 and 3 give a frame of 2048, 1024, 512 or 256 device ticks between sample_o pulses.
- R6: sample_o lasts one cycle and falls on a cycle that is both a device tick and a serial tick.
- R7: With adv_i zero, dac_load_o comes exactly one serial period (S device ticks) before sample_o.
- R8: A value N on adv_i moves dac_load_o earlier by N times (frame/32) device ticks, taken modulo the frame. When the sum equals a whole frame, dac_load_o falls on the same cycle as sample_o. The load always falls on a serial tick.
- R9: A control change made in the middle of a frame leaves the rest of that frame unchanged. The new values take effect from the next sample_o.
- R10: dac_load_o pulses exactly once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdiv_sel_i | input | 3 | Master divider code |
| sclk_sel_i | input | 2 | Serial tick ratio code |
| fs_sel_i | input | 2 | Frame length code |
| adv_i | input | 5 | DAC load advance in frame/32 steps |
| dmclk_en_o | output | 1 | Device clock tick |
| sclk_en_o | output | 1 | Serial bit tick |
| sample_o | output | 1 | Sample / frame strobe |
| dac_load_o | output | 1 | DAC load strobe |

## Verification
The DAC load and the sample strobe can land on the same cycle. This happens when the advance offset plus one serial period adds up to exactly a whole frame. The bench forces it with a 256-tick frame, serial ratio 8 and advance 31. It then checks that both strobes are high on one cycle and that the load still comes once per frame. Two other advance settings stay short of the wrap, and the bench checks the measured gap against the value worked out by modular arithmetic.

// File: rtl/codec_clk_pkg.sv
package codec_clk_pkg;
  localparam int MDIV_W         = 3;
  localparam int SCODE_W        = 2;
  localparam int FCODE_W        = 2;
  localparam int ADV_W          = 5;
  localparam int FRAME_BASE_LOG = 8;
  localparam int MCNT_W         = 3;
  localparam int SCLK_LOG       = (1 << SCODE_W) - 1;
  localparam int CNT_W          = FRAME_BASE_LOG + (1 << FCODE_W) - 1;

  typedef struct packed {
    logic [MDIV_W-1:0]  mdiv;
    logic [SCODE_W-1:0] sdiv;
    logic [FCODE_W-1:0] fs;
    logic [ADV_W-1:0]   adv;
  } clk_cfg_t;

  // terminal count of prescaler (ratio - 1); unused codes alias to /1
  function automatic logic [MCNT_W-1:0] mdiv_last(input logic [MDIV_W-1:0] c);
    case (c)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      3'd4:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] frame_mask(input logic [FCODE_W-1:0] c);
    return {CNT_W{1'b1}} >> c;
  endfunction

  function automatic logic [SCLK_LOG-1:0] sclk_mask(input logic [SCODE_W-1:0] c);
    return {SCLK_LOG{1'b1}} >> c;
  endfunction
endpackage

// File: rtl/mclk_prescaler.sv
module mclk_prescaler
  import codec_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MCNT_W-1:0] last_i,
  output logic              tick_o
);
  logic [MCNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/frame_counter.sv
module frame_counter
  import codec_clk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [CNT_W-1:0]    fmask_i,
  input  logic [SCLK_LOG-1:0] smask_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                sclk_o,
  output logic                frame_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o   = cnt_q;
  assign frame_o = tick_i && (cnt_q == fmask_i);
  // serial ticks are phase-locked to the frame, so a frame end is always one
  assign sclk_o  = tick_i && ((cnt_q[SCLK_LOG-1:0] & smask_i) == smask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (frame_o) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dac_load_gen.sv
module dac_load_gen
  import codec_clk_pkg::*;
(
  input  logic                tick_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [CNT_W-1:0]    fmask_i,
  input  logic [SCLK_LOG-1:0] smask_i,
  input  logic [ADV_W-1:0]    adv_i,
  output logic                load_o
);
  logic [CNT_W-1:0] step, span, target;

  always_comb begin
    step   = (fmask_i >> ADV_W) + 1'b1;
    span   = {{(CNT_W-SCLK_LOG){1'b0}}, smask_i} + 1'b1
           + {{(CNT_W-ADV_W){1'b0}}, adv_i} * step;
    // modulo-frame wrap: a full-frame offset lands on the frame end itself
    target = (fmask_i - span) & fmask_i;
    load_o = tick_i && (cnt_i == target);
  end
endmodule

// File: rtl/codec_clk_chain.sv
module codec_clk_chain
  import codec_clk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MDIV_W-1:0]  mdiv_sel_i,
  input  logic [SCODE_W-1:0] sclk_sel_i,
  input  logic [FCODE_W-1:0] fs_sel_i,
  input  logic [ADV_W-1:0]   adv_i,
  output logic               dmclk_en_o,
  output logic               sclk_en_o,
  output logic               sample_o,
  output logic               dac_load_o
);
  clk_cfg_t            cfg_q;
  logic [MDIV_W-1:0]   act_mdiv;
  logic [CNT_W-1:0]    fmask, cnt;
  logic [SCLK_LOG-1:0] smask;

  assign act_mdiv = cfg_q.mdiv;
  assign fmask    = frame_mask(cfg_q.fs);
  assign smask    = sclk_mask(cfg_q.sdiv);

  // controls are shadowed and only committed on a frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (sample_o) cfg_q <= '{mdiv: mdiv_sel_i, sdiv: sclk_sel_i,
                                  fs: fs_sel_i, adv: adv_i};
  end

  mclk_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_i (mdiv_last(act_mdiv)),
    .tick_o (dmclk_en_o)
  );

  frame_counter u_frm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (dmclk_en_o),
    .fmask_i (fmask),
    .smask_i (smask),
    .cnt_o   (cnt),
    .sclk_o  (sclk_en_o),
    .frame_o (sample_o)
  );

  dac_load_gen u_dac (
    .tick_i  (dmclk_en_o),
    .cnt_i   (cnt),
    .fmask_i (fmask),
    .smask_i (smask),
    .adv_i   (cfg_q.adv),
    .load_o  (dac_load_o)
  );
endmodule

// File: rtl/codec_clk_chain_chk.sv
module codec_clk_chain_chk
  import codec_clk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MDIV_W-1:0] act_mdiv,
  input logic              dmclk_en_o,
  input logic              sclk_en_o,
  input logic              sample_o,
  input logic              dac_load_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!sample_o && !dac_load_o && !sclk_en_o);
    end
  end

  assert_mdiv_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mdiv >= 3'd1 && act_mdiv <= 3'd4 && dmclk_en_o && !sample_o) |=> !dmclk_en_o);

  assert_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mdiv >= 3'd5) |-> dmclk_en_o);

  assert_sclk_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_en_o |-> dmclk_en_o);

  assert_frame_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (sclk_en_o && dmclk_en_o));

  assert_frame_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  assert_load_on_sclk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_load_o |-> sclk_en_o);
endmodule

bind codec_clk_chain codec_clk_chain_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .act_mdiv   (act_mdiv),
  .dmclk_en_o (dmclk_en_o),
  .sclk_en_o  (sclk_en_o),
  .sample_o   (sample_o),
  .dac_load_o (dac_load_o)
);

// File: tb/tb_codec_clk_chain.sv
`timescale 1ns/1ps
module tb_codec_clk_chain;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mdiv = '0;
  logic [1:0] ssel = '0, fsel = '0;
  logic [4:0] adv = '0;
  logic       dmclk_en, sclk_en, sample, dac_load;
  int         total = 0, fails = 0;

  always #2 clk = ~clk;

  codec_clk_chain dut (
    .clk_i(clk), .rst_ni(rst_n), .mdiv_sel_i(mdiv), .sclk_sel_i(ssel),
    .fs_sel_i(fsel), .adv_i(adv), .dmclk_en_o(dmclk_en), .sclk_en_o(sclk_en),
    .sample_o(sample), .dac_load_o(dac_load)
  );

  function automatic logic sig(input int k);
    case (k)
      0: return dmclk_en;
      1: return sclk_en;
      2: return sample;
      default: return dac_load;
    endcase
  endfunction

  function automatic int m_ratio(input int c);
    return (c >= 1 && c <= 4) ? c + 1 : 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(input int k);
    do @(negedge clk); while (!sig(k));
  endtask

  task automatic period(input int k, output int n);
    wait_pulse(k);
    n = 0;
    do begin @(negedge clk); n++; end while (!sig(k));
  endtask

  task automatic set_cfg(input int m, input int s, input int f, input int a);
    @(negedge clk);
    mdiv = 3'(m); ssel = 2'(s); fsel = 2'(f); adv = 5'(a);
    wait_pulse(2);
  endtask

  task automatic dac_gap(output int n);
    wait_pulse(3);
    n = 0;
    while (!sample) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    int n;
    repeat (3) @(negedge clk);
    check("R1 sample in reset", int'(sample), 0);
    check("R1 dac_load in reset", int'(dac_load), 0);
    check("R1 sclk in reset", int'(sclk_en), 0);
    rst_n = 1'b1;
    period(0, n); check("R1 default dmclk period", n, 1);
    period(1, n); check("R1 default sclk period", n, 8);
    period(2, n); check("R1 R5 default frame period", n, 2048);
  endtask

  task automatic t_mdiv;
    int n;
    for (int c = 0; c < 8; c++) begin
      set_cfg(c, 3, 3, 0);
      period(0, n);
      if (c >= 5) check("R3 alias dmclk period", n, 1);
      else        check("R2 dmclk period", n, m_ratio(c));
    end
  endtask

  task automatic t_sclk;
    int n;
    for (int s = 0; s < 4; s++) begin
      set_cfg(1, s, 3, 0);
      period(1, n);
      check("R4 sclk period", n, (8 >> s) * 2);
    end
  endtask

  task automatic t_frame;
    int n;
    for (int f = 0; f < 4; f++) begin
      set_cfg(0, 0, f, 0);
      period(2, n);
      check("R5 frame period", n, 2048 >> f);
    end
  endtask

  task automatic t_dac_default;
    int n;
    set_cfg(0, 0, 3, 0); dac_gap(n); check("R7 load lead s/8", n, 8);
    set_cfg(2, 2, 3, 0); dac_gap(n); check("R7 load lead s/2 m/3", n, 6);
  endtask

  task automatic t_advance;
    int n;
    set_cfg(1, 1, 3, 5);  dac_gap(n); check("R8 advance 5", n, (4 + 5 * 8) * 2);
    set_cfg(0, 2, 1, 31); dac_gap(n); check("R8 advance 31", n, 2 + 31 * 32);
  endtask

  task automatic t_coincide;
    int n, cnt;
    set_cfg(0, 0, 3, 31);
    dac_gap(n);
    check("R8 load coincides with sample", n, 0);
    cnt = 0;
    do begin @(negedge clk); if (dac_load) cnt++; end while (!sample);
    check("R10 one load per wrapped frame", cnt, 1);
  endtask

  task automatic t_once;
    int cnt;
    set_cfg(3, 1, 2, 9);
    wait_pulse(2);
    cnt = 0;
    do begin @(negedge clk); if (dac_load) cnt++; end while (!sample);
    check("R10 one load per frame", cnt, 1);
  endtask

  task automatic t_deferred;
    int n;
    set_cfg(0, 0, 3, 0);
    wait_pulse(2);
    repeat (10) @(negedge clk);
    fsel = 2'd2; mdiv = 3'd1;
    n = 0;
    do begin @(negedge clk); n++; end while (!sample);
    check("R9 current frame kept", n, 246);
    n = 0;
    do begin @(negedge clk); n++; end while (!sample);
    check("R9 new frame applied", n, 512 * 2);
  endtask

  initial begin
    t_reset;
    t_mdiv;
    t_sclk;
    t_frame;
    t_dac_default;
    t_advance;
    t_coincide;
    t_once;
    t_deferred;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule